// File: doc/BRIEF.md
# Aging-Counter Frame Replacement Selector

This block picks which page frame to evict when a new page has to be brought in. It approximates least-recently-used order with a small history register per frame. Each frame holds an 8-bit aging counter and a single "used" flag. A reference strobe with a frame index raises that frame's used flag. An external periodic tick then shifts every counter right by one position and moves the used flag into the top bit, after which the flags start over. As a result, use in the most recent interval outweighs any amount of older use.

When software or a fault handler needs a victim, it pulses a request. One cycle later the block returns the index of the frame whose counter is smallest, together with that counter value. When several frames share the smallest value, the lowest index wins. A load strobe marks a frame as newly filled: its history is wiped and it counts as just used.

Top module: `age_repl_top`

## Requirements
- R1: A reference (`ref_valid` high with `ref_frame` = i) raises frame i's used flag and leaves every other frame's flag unchanged; the flag becomes visible as the top counter bit (value 0x80 and up) after the next tick.
- R2: On a tick, every frame not being loaded in that cycle replaces its counter with {used flag, counter[7:1]}, i.e. shifts right by one with the flag entering bit 7; without a tick or load the counter holds.
- R3: A tick clears each frame's used flag, so a frame that is not referenced during an interval gets a 0 in bit 7 at the following tick.
- R4: A cycle with `victim_req` high is followed, one cycle later, by a single-cycle `victim_valid` pulse; `victim_frame` and `victim_age` then give the frame with the smallest counter value and that value, as the counters stood in the request cycle.
- R5: When several frames share the smallest counter value, the lowest frame index is returned.
- R6: A reference in the same cycle as a tick is not lost: it sets the flag after the clear and so counts for the following interval.
- R7: A load (`load_valid` high with `load_frame` = i) sets frame i's counter to 0 and its used flag to 1, taking priority over a tick or a reference to that frame in the same cycle.
- R8: Synchronous reset clears all counters, all used flags and `victim_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Reference strobe |
| ref_frame | input | IDX_W | Frame index being referenced |
| tick | input | 1 | Periodic aging strobe |
| load_valid | input | 1 | Load strobe for a newly filled frame |
| load_frame | input | IDX_W | Frame index being loaded |
| victim_req | input | 1 | Request for a replacement choice |
| victim_valid | output | 1 | Victim outputs valid (one cycle after request) |
| victim_frame | output | IDX_W | Index of the chosen frame |
| victim_age | output | AGE_W | Counter value of the chosen frame |

## Verification
One fixed program of references, ticks, loads and requests is applied in sequence. The frames then carry counters that differ only in lower bits, differ in the top bit, or are equal. The differing-low-bit cases show whether the shift moves history toward the least significant end. The top-bit cases tell a recent reference apart from older ones. The equal cases show the lowest-index tie break. A reference issued in the same cycle as a tick, and a load issued in the same cycle as a tick, separate the "counted next interval" rule and load priority from a design that drops or merges these events. Directed tests then cover the reset state, a reset in the middle of a run, and the single-cycle length of the response pulse.

// File: rtl/age_repl_pkg.sv
package age_repl_pkg;

    // Per-frame command decoded from the block inputs in one cycle.
    typedef struct packed {
        logic hit;   // frame referenced this cycle
        logic load;  // frame newly filled this cycle
        logic tick;  // periodic aging strobe
    } slot_cmd_t;

    // State held for one frame.
    typedef struct packed {
        logic       used;
        logic [7:0] age;
    } slot_state_t;

    // Age update on a tick: history moves toward bit 0, latest flag enters at the top.
    function automatic logic [7:0] age_step(input logic [7:0] age, input logic used);
        return {used, age[7:1]};
    endfunction

    // True when candidate should replace the running choice (strictly smaller keeps lower index).
    function automatic logic age_better(input logic [7:0] cand, input logic [7:0] best);
        return cand < best;
    endfunction

endpackage

// File: rtl/age_frame_slot.sv
module age_frame_slot
    import age_repl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  slot_cmd_t   cmd,
    output logic [7:0]  age_o
);

    slot_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (cmd.load) begin
            st_d.age  = '0;
            st_d.used = 1'b1;
        end else begin
            if (cmd.tick) begin
                st_d.age  = age_step(st_q.age, st_q.used);
                st_d.used = 1'b0;
            end
            if (cmd.hit) begin
                st_d.used = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign age_o = st_q.age;

    AST_REF_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        cmd.hit |=> st_q.used); // R1
    AST_TICK_LOW_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (cmd.tick && !cmd.load) |=> st_q.age[6:0] == $past(st_q.age[7:1])); // R2
    AST_TICK_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
        (cmd.tick && !cmd.load) |=> st_q.age[7] == $past(st_q.used)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd.tick && !cmd.load) |=> $stable(st_q.age)); // R2
    AST_TICK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cmd.tick && !cmd.load && !cmd.hit) |=> !st_q.used); // R3
    AST_TICK_REF_KEPT: assert property (@(posedge clk) disable iff (rst)
        (cmd.tick && cmd.hit) |=> st_q.used); // R6
    AST_LOAD_INIT: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (st_q.age == '0 && st_q.used)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (st_q.age == '0 && !st_q.used)); // R8

endmodule

// File: rtl/age_min_sel.sv
module age_min_sel
    import age_repl_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic [NUM_FRAMES-1:0][7:0] ages,
    output logic [IDX_W-1:0]           min_idx,
    output logic [7:0]                 min_age
);

    logic [NUM_FRAMES-1:0][7:0]       run_age;
    logic [NUM_FRAMES-1:0][IDX_W-1:0] run_idx;

    genvar i;
    generate
        for (i = 0; i < NUM_FRAMES; i++) begin : g_chain
            if (i == 0) begin : g_first
                assign run_age[i] = ages[i];
                assign run_idx[i] = '0;
            end else begin : g_next
                logic take;
                assign take       = age_better(ages[i], run_age[i-1]);
                assign run_age[i] = take ? ages[i] : run_age[i-1];
                assign run_idx[i] = take ? IDX_W'(i) : run_idx[i-1];
            end
        end
    endgenerate

    assign min_idx = run_idx[NUM_FRAMES-1];
    assign min_age = run_age[NUM_FRAMES-1];

endmodule

// File: rtl/age_victim_port.sv
module age_victim_port #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic [7:0]       sel_age,
    output logic             valid_o,
    output logic [IDX_W-1:0] frame_o,
    output logic [7:0]       age_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            frame_o <= '0;
            age_o   <= '0;
        end else begin
            valid_o <= req;
            if (req) begin
                frame_o <= sel_idx;
                age_o   <= sel_age;
            end
        end
    end

    AST_VICTIM_PULSE: assert property (@(posedge clk) disable iff (rst)
        req |=> valid_o); // R4
    AST_VICTIM_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req |=> !valid_o); // R4
    AST_VALID_RESET: assert property (@(posedge clk)
        rst |=> !valid_o); // R8

endmodule

// File: rtl/age_repl_top.sv
module age_repl_top
    import age_repl_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W     = $clog2(NUM_FRAMES),
    localparam int AGE_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_frame,
    input  logic             tick,
    input  logic             load_valid,
    input  logic [IDX_W-1:0] load_frame,
    input  logic             victim_req,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_frame,
    output logic [AGE_W-1:0] victim_age
);

    logic [NUM_FRAMES-1:0][7:0] frame_age;
    logic [IDX_W-1:0]           sel_idx;
    logic [7:0]                 sel_age;

    genvar i;
    generate
        for (i = 0; i < NUM_FRAMES; i++) begin : g_slot
            slot_cmd_t cmd;
            assign cmd.hit  = ref_valid  && (ref_frame  == IDX_W'(i));
            assign cmd.load = load_valid && (load_frame == IDX_W'(i));
            assign cmd.tick = tick;

            age_frame_slot u_slot (
                .clk   (clk),
                .rst   (rst),
                .cmd   (cmd),
                .age_o (frame_age[i])
            );

            AST_VICTIM_NOT_ABOVE: assert property (@(posedge clk) disable iff (rst)
                victim_valid |-> victim_age <= $past(frame_age[i])); // R4
            AST_TIE_LOW_INDEX: assert property (@(posedge clk) disable iff (rst)
                (victim_valid && victim_age == $past(frame_age[i]))
                    |-> victim_frame <= IDX_W'(i)); // R5
        end
    endgenerate

    age_min_sel #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_min (
        .ages    (frame_age),
        .min_idx (sel_idx),
        .min_age (sel_age)
    );

    age_victim_port #(
        .IDX_W (IDX_W)
    ) u_port (
        .clk     (clk),
        .rst     (rst),
        .req     (victim_req),
        .sel_idx (sel_idx),
        .sel_age (sel_age),
        .valid_o (victim_valid),
        .frame_o (victim_frame),
        .age_o   (victim_age)
    );

endmodule

// File: tb/tb_age_repl_top.sv
`timescale 1ns/1ps
module tb_age_repl_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       ref_valid, tick, load_valid, victim_req;
    logic [2:0] ref_frame, load_frame;
    logic       victim_valid;
    logic [2:0] victim_frame;
    logic [7:0] victim_age;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk; // 50 MHz

    age_repl_top #(.NUM_FRAMES(8)) dut (
        .clk(clk), .rst(rst),
        .ref_valid(ref_valid), .ref_frame(ref_frame),
        .tick(tick),
        .load_valid(load_valid), .load_frame(load_frame),
        .victim_req(victim_req),
        .victim_valid(victim_valid), .victim_frame(victim_frame), .victim_age(victim_age)
    );

    typedef struct packed {
        logic       rv;
        logic [2:0] rf;
        logic       tk;
        logic       lv;
        logic [2:0] lf;
        logic       rq;
        logic [2:0] ef;
        logic [7:0] ea;
        logic [3:0] rid;
    } vec_t;

    localparam int NV = 21;
    // rv rf tk lv lf rq | expected frame, age, requirement
    localparam vec_t VEC [NV] = '{
        '{1'b1,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd0,8'h00,4'd5}, // R5 all zero after reset
        '{1'b1,3'd1,1'b0,1'b0,3'd0,1'b0, 3'd0,8'h00,4'd0},
        '{1'b1,3'd2,1'b1,1'b0,3'd0,1'b0, 3'd0,8'h00,4'd0}, // ref with tick
        '{1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd2,8'h00,4'd1}, // R1 f0,f1 at 0x80
        '{1'b0,3'd0,1'b1,1'b0,3'd0,1'b0, 3'd0,8'h00,4'd0}, // R6 f2 gets 0x80
        '{1'b1,3'd3,1'b0,1'b0,3'd0,1'b0, 3'd0,8'h00,4'd0},
        '{1'b0,3'd0,1'b1,1'b0,3'd0,1'b0, 3'd0,8'h00,4'd0},
        '{1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd4,8'h00,4'd3}, // R3 unreferenced stay 0
        '{1'b1,3'd4,1'b0,1'b0,3'd0,1'b0, 3'd0,8'h00,4'd0},
        '{1'b1,3'd5,1'b0,1'b0,3'd0,1'b0, 3'd0,8'h00,4'd0},
        '{1'b1,3'd6,1'b0,1'b0,3'd0,1'b0, 3'd0,8'h00,4'd0},
        '{1'b1,3'd7,1'b0,1'b0,3'd0,1'b0, 3'd0,8'h00,4'd0},
        '{1'b0,3'd0,1'b1,1'b0,3'd0,1'b0, 3'd0,8'h00,4'd0},
        '{1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd0,8'h10,4'd5}, // R5 f0,f1 tie at 0x10
        '{1'b1,3'd0,1'b0,1'b0,3'd0,1'b0, 3'd0,8'h00,4'd0},
        '{1'b0,3'd0,1'b1,1'b0,3'd0,1'b0, 3'd0,8'h00,4'd0},
        '{1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd1,8'h08,4'd2}, // R2 f0 0x88, f1 0x08
        '{1'b1,3'd1,1'b1,1'b1,3'd1,1'b0, 3'd0,8'h00,4'd0}, // load+tick+ref on f1
        '{1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd1,8'h00,4'd7}, // R7 f1 cleared
        '{1'b0,3'd0,1'b1,1'b0,3'd0,1'b0, 3'd0,8'h00,4'd0},
        '{1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd2,8'h04,4'd2}  // R2 f1 0x80, f2 0x04
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ref_valid = 0; ref_frame = 0; tick = 0;
        load_valid = 0; load_frame = 0; victim_req = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R8: reset state, no response pending
        chk("R8 valid after reset", victim_valid, 0);
        @(negedge clk);
        chk("R4 no pulse without request", victim_valid, 0);

        for (int k = 0; k < NV; k++) begin
            ref_valid  = VEC[k].rv; ref_frame  = VEC[k].rf;
            tick       = VEC[k].tk;
            load_valid = VEC[k].lv; load_frame = VEC[k].lf;
            victim_req = VEC[k].rq;
            @(negedge clk);
            if (VEC[k].rq) begin
                chk($sformatf("R%0d vec%0d valid", VEC[k].rid, k), victim_valid, 1);
                chk($sformatf("R%0d vec%0d frame", VEC[k].rid, k), victim_frame, VEC[k].ef);
                chk($sformatf("R%0d vec%0d age", VEC[k].rid, k), victim_age, VEC[k].ea);
            end
            idle();
        end

        // R4: pulse lasts a single cycle
        @(negedge clk);
        chk("R4 pulse single cycle", victim_valid, 0);

        // R4: counters sampled in request cycle, not after a simultaneous tick.
        // state: f0 22 f1 80 f2 04 f3 08 f4-7 10; req+tick -> report f2 04
        victim_req = 1; tick = 1;
        @(negedge clk);
        idle();
        chk("R4 pre-tick frame", victim_frame, 2);
        chk("R4 pre-tick age", victim_age, 8'h04);
        // now f2 = 0x02
        victim_req = 1;
        @(negedge clk);
        idle();
        chk("R2 after extra tick", victim_age, 8'h02);

        // R8: reset mid-run clears all history
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R8 valid cleared", victim_valid, 0);
        ref_valid = 1; ref_frame = 0;
        @(negedge clk);
        ref_valid = 0; ref_frame = 5; ref_valid = 1; tick = 1;
        @(negedge clk);
        idle();
        // f0 0x80, f5 R=1 (R6), others 0
        victim_req = 1;
        @(negedge clk);
        idle();
        chk("R8 frame after reset", victim_frame, 1);
        chk("R8 age after reset", victim_age, 8'h00);

        finish_run();
    end

endmodule